// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Interrupt Unit

This block watches the raw readings of up to four on-die temperature sensor channels and turns threshold crossings into interrupt events. Each channel presents a measurement word with a sample strobe. The raw code falls as the die heats, so "hotter than a threshold" means "code below the threshold". Every valid sample is compared with the previous valid sample of the same channel against four shared thresholds: hot, cold, high offset and low offset. An event is raised only when the pair of samples straddles a threshold, so a sensor that stays hot does not keep raising events.

Events are latched into a 32-bit status word, and software clears them by writing ones. A 32-bit enable word with the same layout masks them onto one registered interrupt line. A protection comparator takes the latest code of every channel and forms one value from them: the average, the hottest channel, or one chosen channel. It flags three stages when that value drops below three programmable stage thresholds. Stage 3 is the shutdown stage. An external device-access timeout pulse is also recorded in the status word.

Top module: `thermal_event_irq`

## Requirements
- R1: After a synchronous active-low reset, every register (status, enable, the four sensor thresholds, control, the three stage thresholds) reads 0 and `irq` is low.
- R2: Status layout: channel s (s = 0,1,2) owns bits 5s..5s+4 and channel 3 owns bits 22..26. Within each group the offsets are +0 cold, +1 hot, +2 low offset, +3 high offset, +4 normal-to-hot. Bit 15 records an `access_timeout` pulse. Bits 29, 30 and 31 record protection stages 1, 2 and 3. All other bits stay 0.
- R3: A sample counts only when its strobe is high and its valid flag (bit 16 of the channel's 17-bit word, raw code in bits 15..0) is set. An uncounted sample raises no event and does not replace the stored previous code. The first counted sample after reset raises no event.
- R4: Hot event: the previous code is at least the hot threshold and the new code is below it. The high-offset event follows the same rule against the high-offset threshold.
- R5: Cold event: the previous code is at most the cold threshold and the new code is above it. The low-offset event follows the same rule against the low-offset threshold.
- R6: Normal-to-hot: with control bit 4 = 0 it fires on every hot event. With bit 4 = 1 it fires only while the channel is armed. The channel is armed at reset, disarmed by a hot event in that mode, and re-armed by a cold event.
- R7: Writing a 1 to a status bit clears it. A bit set by an event in the same cycle as its clear stays set.
- R8: `irq` is a register that, one cycle later, shows whether any status bit is set together with its enable bit.
- R9: Register map by word address: 0 status, 1 enable, 2 low offset, 3 high offset, 4 hot, 5 cold, 6 control, 7..9 stage 1..3 thresholds. Thresholds keep bits 14..0, control keeps bits 4..0, unused bits read 0, and unmapped addresses read 0.
- R10: Protection value, chosen by control bits 1..0: 00 gives the sum of the four latest codes shifted right by 2; 01 gives the smallest latest code (hottest); 10 or 11 gives the latest code of the channel in control bits 3..2. Latest codes reset to 16'hFFFF and change only on counted samples.
- R11: A stage bit is set one cycle after the protection value goes from not-below to below that stage's threshold. It is not set again while the value stays below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_strobe | input | 4 | Per-channel new-sample strobe |
| samp_word | input | 68 | Per-channel 17-bit measurement word, channel s at bits 17s+16..17s |
| access_timeout | input | 1 | Device-access timeout pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: four channels, 16-bit codes and 15-bit thresholds. With these values the status gap from bit 14 to bit 22 for the last channel and the divide-by-four in the average mode both come into play. It also lets random codes near the thresholds hit every crossing direction on every channel. The thresholds sit inside a narrow code window, so the average, hottest and single-channel protection modes cross all three stages often. The once-per-heating behaviour, same-cycle set and clear, and masked interrupts are also driven on purpose.

// File: rtl/tiu_pkg.sv
// Package: shared constants for the thermal event interrupt unit.
// Holds the status layout, the register word addresses and the
// protection source codes. The status layout is fixed at 32 bits.
package tiu_pkg;

    localparam int STAT_W      = 32;
    localparam int EVT_N       = 5;
    // Event offsets inside one channel's status group
    localparam int EV_COLD     = 0;
    localparam int EV_HOT      = 1;
    localparam int EV_LOW      = 2;
    localparam int EV_HIGH     = 3;
    localparam int EV_NTOH     = 4;
    localparam int BIT_TIMEOUT = 15;
    localparam int BIT_STAGE1  = 29;

    // Register word addresses
    localparam int A_STATUS   = 0;
    localparam int A_ENABLE   = 1;
    localparam int A_LOW_OFF  = 2;
    localparam int A_HIGH_OFF = 3;
    localparam int A_HOT      = 4;
    localparam int A_COLD     = 5;
    localparam int A_CTRL     = 6;
    localparam int A_STAGE1   = 7;

    // Protection source codes
    localparam logic [1:0] PROT_AVG     = 2'd0;
    localparam logic [1:0] PROT_HOTTEST = 2'd1;

    // First status bit of a channel's event group
    function automatic int sens_base(input int s);
        return (s < 3) ? 5 * s : 22;
    endfunction

endpackage

// File: rtl/tiu_sensor_cmp.sv
// Module: per-channel crossing detector.
// Keeps the last counted code of one channel and flags the threshold
// crossings between it and a new counted sample. The stored code also
// serves as the channel's latest value for the protection comparator.
// Assumes thresholds are zero-extended 15-bit codes; a lower code means hotter.
module tiu_sensor_cmp
    import tiu_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int THR_W  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [CODE_W:0]   word,
    input  logic [THR_W-1:0]  thr_low,
    input  logic [THR_W-1:0]  thr_high,
    input  logic [THR_W-1:0]  thr_hot,
    input  logic [THR_W-1:0]  thr_cold,
    input  logic              once_mode,
    output logic [EVT_N-1:0]  evt,
    output logic [CODE_W-1:0] last_code
);
    localparam logic [CODE_W-1:0] IDLE_CODE = '1;

    logic              take, pair, hot_x, cold_x;
    logic [CODE_W-1:0] cur, prev_q;
    logic [CODE_W-1:0] low_w, high_w, hot_w, cold_w;
    logic              has_prev_q, armed_q;

    // Decode the sample and compare it with the stored one
    always_comb begin
        take   = strobe & word[CODE_W];
        cur    = word[CODE_W-1:0];
        pair   = take & has_prev_q;
        low_w  = CODE_W'(thr_low);
        high_w = CODE_W'(thr_high);
        hot_w  = CODE_W'(thr_hot);
        cold_w = CODE_W'(thr_cold);
        hot_x  = pair && (prev_q >= hot_w) && (cur < hot_w);
        cold_x = pair && (prev_q <= cold_w) && (cur > cold_w);
        evt          = '0;
        evt[EV_HOT]  = hot_x;
        evt[EV_COLD] = cold_x;
        evt[EV_HIGH] = pair && (prev_q >= high_w) && (cur < high_w);
        evt[EV_LOW]  = pair && (prev_q <= low_w) && (cur > low_w);
        evt[EV_NTOH] = hot_x && (!once_mode || armed_q);
    end

    // Store the last counted sample and the once-mode arming flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= IDLE_CODE;
            has_prev_q <= 1'b0;
            armed_q    <= 1'b1;
        end else begin
            if (take) begin
                prev_q     <= cur;
                has_prev_q <= 1'b1;
            end
            if (hot_x && once_mode) armed_q <= 1'b0;
            else if (cold_x)        armed_q <= 1'b1;
        end
    end

    assign last_code = prev_q;

    // R3: an uncounted sample raises nothing
    a_r3_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && word[CODE_W]) |-> (evt == '0));
    // R3: the first counted sample has no predecessor
    a_r3_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !has_prev_q) |-> (evt == '0));
    // R6: normal-to-hot only accompanies a hot crossing
    a_r6_ntoh_with_hot: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EV_NTOH] |-> evt[EV_HOT]);
    // R5: a sample cannot cross hot downward and cold upward at once
    a_r5_no_both_ways: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt[EV_HOT] && evt[EV_COLD]));

endmodule

// File: rtl/tiu_protect.sv
// Module: protection comparator.
// Builds one code from the channels' latest codes (average, hottest or
// one selected channel) and flags each stage when that code first
// drops below the stage threshold. Assumes NUM_SENS is a power of two.
module tiu_protect
    import tiu_pkg::*;
#(
    parameter int CODE_W     = 16,
    parameter int THR_W      = 15,
    parameter int NUM_SENS   = 4,
    parameter int NUM_STAGES = 3,
    parameter int SEL_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SENS*CODE_W-1:0]   held,
    input  logic [1:0]                   mode,
    input  logic [SEL_W-1:0]             sel,
    input  logic [NUM_STAGES*THR_W-1:0]  stage_thr,
    output logic [NUM_STAGES-1:0]        stage_evt
);
    localparam int AVG_SH = $clog2(NUM_SENS);
    localparam int SUM_W  = CODE_W + AVG_SH;

    logic [SUM_W-1:0]      sum;
    logic [CODE_W-1:0]     hottest, prot_val;
    logic [NUM_STAGES-1:0] below_now, below_q;

    // Reduce the latest codes to the selected protection value
    always_comb begin
        sum     = '0;
        hottest = '1;
        for (int i = 0; i < NUM_SENS; i++) begin
            sum = sum + SUM_W'(held[i*CODE_W +: CODE_W]);
            if (held[i*CODE_W +: CODE_W] < hottest) hottest = held[i*CODE_W +: CODE_W];
        end
        case (mode)
            PROT_AVG:     prot_val = CODE_W'(sum >> AVG_SH);
            PROT_HOTTEST: prot_val = hottest;
            default:      prot_val = held[sel*CODE_W +: CODE_W];
        endcase
    end

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        // Compare against this stage's threshold
        assign below_now[k] = prot_val < CODE_W'(stage_thr[k*THR_W +: THR_W]);

        // Remember last cycle's comparison for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) below_q[k] <= 1'b0;
            else        below_q[k] <= below_now[k];
        end

        assign stage_evt[k] = below_now[k] & ~below_q[k];

        // R11: one event per entry below the threshold
        a_r11_stage_single: assert property (@(posedge clk) disable iff (!rst_n)
            stage_evt[k] |=> !stage_evt[k]);
    end

endmodule

// File: rtl/tiu_regs.sv
// Module: register file, status latch and interrupt register.
// Word-addressed write port with combinational read. Status bits are
// write-one-to-clear, and a same-cycle set wins over the clear.
// Assumes set_vec only drives bits of the defined status layout.
module tiu_regs
    import tiu_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int THR_W      = 15,
    parameter int NUM_STAGES = 3,
    parameter int SEL_W      = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [STAT_W-1:0]           reg_wdata,
    output logic [STAT_W-1:0]           reg_rdata,
    input  logic [STAT_W-1:0]           set_vec,
    output logic                        irq,
    output logic [THR_W-1:0]            thr_low,
    output logic [THR_W-1:0]            thr_high,
    output logic [THR_W-1:0]            thr_hot,
    output logic [THR_W-1:0]            thr_cold,
    output logic [1:0]                  ctrl_mode,
    output logic [SEL_W-1:0]            ctrl_sel,
    output logic                        ctrl_once,
    output logic [NUM_STAGES*THR_W-1:0] stage_thr
);
    localparam int CTRL_W = 3 + SEL_W;

    logic [STAT_W-1:0] status_q, enable_q, clr_vec;
    logic [THR_W-1:0]  low_q, high_q, hot_q, cold_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [THR_W-1:0]  stage_q [NUM_STAGES];
    logic              irq_q;

    // Write-one-to-clear mask for the status word
    always_comb clr_vec = (reg_we && reg_addr == ADDR_W'(A_STATUS)) ? reg_wdata : '0;

    // Latch events; a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            low_q    <= '0;
            high_q   <= '0;
            hot_q    <= '0;
            cold_q   <= '0;
            ctrl_q   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_W'(A_ENABLE):   enable_q <= reg_wdata;
                ADDR_W'(A_LOW_OFF):  low_q    <= reg_wdata[THR_W-1:0];
                ADDR_W'(A_HIGH_OFF): high_q   <= reg_wdata[THR_W-1:0];
                ADDR_W'(A_HOT):      hot_q    <= reg_wdata[THR_W-1:0];
                ADDR_W'(A_COLD):     cold_q   <= reg_wdata[THR_W-1:0];
                ADDR_W'(A_CTRL):     ctrl_q   <= reg_wdata[CTRL_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage_reg
        // Stage threshold write
        always_ff @(posedge clk) begin
            if (!rst_n)
                stage_q[k] <= '0;
            else if (reg_we && reg_addr == ADDR_W'(A_STAGE1 + k))
                stage_q[k] <= reg_wdata[THR_W-1:0];
        end
        assign stage_thr[k*THR_W +: THR_W] = stage_q[k];
    end

    // Registered interrupt from masked status
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & enable_q);
    end

    // Combinational read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_STATUS):   reg_rdata = status_q;
            ADDR_W'(A_ENABLE):   reg_rdata = enable_q;
            ADDR_W'(A_LOW_OFF):  reg_rdata = STAT_W'(low_q);
            ADDR_W'(A_HIGH_OFF): reg_rdata = STAT_W'(high_q);
            ADDR_W'(A_HOT):      reg_rdata = STAT_W'(hot_q);
            ADDR_W'(A_COLD):     reg_rdata = STAT_W'(cold_q);
            ADDR_W'(A_CTRL):     reg_rdata = STAT_W'(ctrl_q);
            default: ;
        endcase
        for (int k = 0; k < NUM_STAGES; k++)
            if (reg_addr == ADDR_W'(A_STAGE1 + k)) reg_rdata = STAT_W'(stage_q[k]);
    end

    assign irq       = irq_q;
    assign thr_low   = low_q;
    assign thr_high  = high_q;
    assign thr_hot   = hot_q;
    assign thr_cold  = cold_q;
    assign ctrl_mode = ctrl_q[1:0];
    assign ctrl_sel  = ctrl_q[2 +: SEL_W];
    assign ctrl_once = ctrl_q[2+SEL_W];

    // R7: an event set survives a same-cycle clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    // R7: cleared bits without a new event read 0 next cycle
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));
    // R8: nothing enabled last cycle means no interrupt
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable_q) == '0) |-> !irq);
    // R9: threshold words read 0 above bit 14
    a_r9_thr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(A_LOW_OFF) && reg_addr <= ADDR_W'(A_COLD))
            |-> (reg_rdata[STAT_W-1:THR_W] == '0));

endmodule

// File: rtl/thermal_event_irq.sv
// Module: top of the thermal event interrupt unit.
// Instantiates one crossing detector per channel, the protection
// comparator and the register file, and maps events onto the status
// layout. Assumes at most four channels, as the status layout is fixed.
module thermal_event_irq
    import tiu_pkg::*;
#(
    parameter int NUM_SENS   = 4,
    parameter int CODE_W     = 16,
    parameter int THR_W      = 15,
    parameter int NUM_STAGES = 3,
    parameter int ADDR_W     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SENS-1:0]            samp_strobe,
    input  logic [NUM_SENS*(CODE_W+1)-1:0] samp_word,
    input  logic                           access_timeout,
    input  logic                           reg_we,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [STAT_W-1:0]              reg_wdata,
    output logic [STAT_W-1:0]              reg_rdata,
    output logic                           irq
);
    localparam int WORD_W = CODE_W + 1;
    localparam int SEL_W  = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1;

    logic [THR_W-1:0]            thr_low, thr_high, thr_hot, thr_cold;
    logic [1:0]                  ctrl_mode;
    logic [SEL_W-1:0]            ctrl_sel;
    logic                        ctrl_once;
    logic [NUM_STAGES*THR_W-1:0] stage_thr;
    logic [NUM_SENS*EVT_N-1:0]   evt_flat;
    logic [NUM_SENS*CODE_W-1:0]  held;
    logic [NUM_STAGES-1:0]       stage_evt;
    logic [STAT_W-1:0]           set_vec;

    for (genvar s = 0; s < NUM_SENS; s++) begin : g_sens
        tiu_sensor_cmp #(.CODE_W(CODE_W), .THR_W(THR_W)) i_cmp (
            .clk       (clk),
            .rst_n     (rst_n),
            .strobe    (samp_strobe[s]),
            .word      (samp_word[s*WORD_W +: WORD_W]),
            .thr_low   (thr_low),
            .thr_high  (thr_high),
            .thr_hot   (thr_hot),
            .thr_cold  (thr_cold),
            .once_mode (ctrl_once),
            .evt       (evt_flat[s*EVT_N +: EVT_N]),
            .last_code (held[s*CODE_W +: CODE_W])
        );
    end

    tiu_protect #(
        .CODE_W(CODE_W), .THR_W(THR_W), .NUM_SENS(NUM_SENS),
        .NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)
    ) i_protect (
        .clk       (clk),
        .rst_n     (rst_n),
        .held      (held),
        .mode      (ctrl_mode),
        .sel       (ctrl_sel),
        .stage_thr (stage_thr),
        .stage_evt (stage_evt)
    );

    // Scatter all events onto the status layout
    always_comb begin
        set_vec = '0;
        for (int s = 0; s < NUM_SENS; s++)
            set_vec[sens_base(s) +: EVT_N] = evt_flat[s*EVT_N +: EVT_N];
        set_vec[BIT_TIMEOUT] = access_timeout;
        for (int k = 0; k < NUM_STAGES; k++)
            set_vec[BIT_STAGE1 + k] = stage_evt[k];
    end

    tiu_regs #(
        .ADDR_W(ADDR_W), .THR_W(THR_W), .NUM_STAGES(NUM_STAGES), .SEL_W(SEL_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_vec   (set_vec),
        .irq       (irq),
        .thr_low   (thr_low),
        .thr_high  (thr_high),
        .thr_hot   (thr_hot),
        .thr_cold  (thr_cold),
        .ctrl_mode (ctrl_mode),
        .ctrl_sel  (ctrl_sel),
        .ctrl_once (ctrl_once),
        .stage_thr (stage_thr)
    );

endmodule

// File: tb/test_thermal_event_irq.sv
// Bench: directed corner cases plus seeded random traffic, checked
// against a behavioural model kept in bench variables.
module test_thermal_event_irq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  samp_strobe;
    logic [67:0] samp_word;
    logic        access_timeout;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;

    thermal_event_irq i_thermal_event_irq (
        .clk(clk), .rst_n(rst_n), .samp_strobe(samp_strobe), .samp_word(samp_word),
        .access_timeout(access_timeout), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state
    logic [15:0] m_prev [4];
    bit          m_has  [4];
    bit          m_armed[4];
    logic [31:0] m_status, m_en;
    logic [14:0] m_low, m_high, m_hot, m_cold;
    logic [14:0] m_stage[3];
    logic [4:0]  m_ctrl;
    bit          m_below[3];
    bit          m_irq;

    function automatic int base_of(input int s);
        return (s < 3) ? 5 * s : 22;
    endfunction

    function automatic logic [15:0] exp_prot();
        logic [17:0] sum = '0;
        logic [15:0] hot = 16'hFFFF;
        for (int s = 0; s < 4; s++) begin
            sum = sum + 18'(m_prev[s]);
            if (m_prev[s] < hot) hot = m_prev[s];
        end
        case (m_ctrl[1:0])
            2'd0:    return sum[17:2];
            2'd1:    return hot;
            default: return m_prev[m_ctrl[3:2]];
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            m_prev[s] = 16'hFFFF; m_has[s] = 0; m_armed[s] = 1;
        end
        m_status = 0; m_en = 0; m_low = 0; m_high = 0; m_hot = 0; m_cold = 0;
        for (int k = 0; k < 3; k++) begin m_stage[k] = 0; m_below[k] = 0; end
        m_ctrl = 0; m_irq = 0;
    endtask

    // Model of one clock edge with the inputs that were driven before it
    task automatic model_edge(input logic [3:0] stb, input logic [3:0] vld,
                              input logic [63:0] codes, input bit tmo, input bit we,
                              input logic [3:0] addr, input logic [31:0] wdata);
        logic [31:0] set = '0;
        logic [31:0] clr;
        logic [15:0] pv;
        bit bn[3];
        bit hot_x[4];
        bit cold_x[4];
        bit irq_next;
        clr = (we && addr == 4'd0) ? wdata : 32'd0;
        irq_next = |(m_status & m_en);
        pv = exp_prot();
        for (int k = 0; k < 3; k++) begin
            bn[k] = pv < {1'b0, m_stage[k]};
            if (bn[k] && !m_below[k]) set[29+k] = 1'b1;
        end
        for (int s = 0; s < 4; s++) begin
            logic [15:0] c;
            bit pair;
            c = codes[s*16 +: 16];
            pair = stb[s] && vld[s] && m_has[s];
            hot_x[s]  = pair && m_prev[s] >= {1'b0, m_hot}  && c < {1'b0, m_hot};
            cold_x[s] = pair && m_prev[s] <= {1'b0, m_cold} && c > {1'b0, m_cold};
            set[base_of(s)+0] = cold_x[s];
            set[base_of(s)+1] = hot_x[s];
            set[base_of(s)+2] = pair && m_prev[s] <= {1'b0, m_low}  && c > {1'b0, m_low};
            set[base_of(s)+3] = pair && m_prev[s] >= {1'b0, m_high} && c < {1'b0, m_high};
            set[base_of(s)+4] = hot_x[s] && (!m_ctrl[4] || m_armed[s]);
        end
        if (tmo) set[15] = 1'b1;
        m_status = (m_status & ~clr) | set;
        for (int s = 0; s < 4; s++) begin
            if (stb[s] && vld[s]) begin
                m_prev[s] = codes[s*16 +: 16];
                m_has[s]  = 1;
            end
            if (hot_x[s] && m_ctrl[4]) m_armed[s] = 0;
            else if (cold_x[s])        m_armed[s] = 1;
        end
        for (int k = 0; k < 3; k++) m_below[k] = bn[k];
        m_irq = irq_next;
        if (we) begin
            case (addr)
                4'd1: m_en   = wdata;
                4'd2: m_low  = wdata[14:0];
                4'd3: m_high = wdata[14:0];
                4'd4: m_hot  = wdata[14:0];
                4'd5: m_cold = wdata[14:0];
                4'd6: m_ctrl = wdata[4:0];
                4'd7: m_stage[0] = wdata[14:0];
                4'd8: m_stage[1] = wdata[14:0];
                4'd9: m_stage[2] = wdata[14:0];
                default: ;
            endcase
        end
    endtask

    // One clock: drive, model the edge, then check status and irq
    task automatic cycle(input string tag, input logic [3:0] stb, input logic [3:0] vld,
                         input logic [63:0] codes, input bit tmo, input bit we,
                         input logic [3:0] addr, input logic [31:0] wdata);
        samp_strobe = stb;
        for (int s = 0; s < 4; s++) samp_word[s*17 +: 17] = {vld[s], codes[s*16 +: 16]};
        access_timeout = tmo;
        reg_we = we; reg_addr = addr; reg_wdata = wdata;
        @(posedge clk);
        model_edge(stb, vld, codes, tmo, we, addr, wdata);
        @(negedge clk);
        samp_strobe = 0; access_timeout = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        #1;
        check({tag, " status"}, reg_rdata, m_status);
        check({tag, " irq"}, {31'd0, irq}, {31'd0, m_irq});
    endtask

    task automatic wr(input string tag, input logic [3:0] addr, input logic [31:0] data);
        cycle(tag, 4'd0, 4'd0, 64'd0, 1'b0, 1'b1, addr, data);
    endtask

    task automatic idle(input string tag);
        cycle(tag, 4'd0, 4'd0, 64'd0, 1'b0, 1'b0, 4'd0, 32'd0);
    endtask

    task automatic one(input string tag, input int s, input logic [15:0] code, input bit v);
        cycle(tag, 4'(1 << s), 4'(v << s), 64'(code) << (16 * s), 1'b0, 1'b0, 4'd0, 32'd0);
    endtask

    task automatic rd_check(input string tag, input logic [3:0] addr, input logic [31:0] exp);
        reg_addr = addr;
        #1;
        check(tag, reg_rdata, exp);
        reg_addr = 0;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        samp_strobe = 0; samp_word = '0; access_timeout = 0;
        reg_we = 0; reg_addr = 0; reg_wdata = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;

        // R1: reset values of every register and irq
        for (int a = 0; a < 10; a++) rd_check("R1 reset register", 4'(a), 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        // R9: readback masks and unmapped address
        for (int a = 1; a < 10; a++) wr("R9 write ones", 4'(a), 32'hFFFF_FFFF);
        rd_check("R9 enable readback", 4'd1, 32'hFFFF_FFFF);
        for (int a = 2; a < 6; a++) rd_check("R9 threshold mask", 4'(a), 32'h0000_7FFF);
        rd_check("R9 control mask", 4'd6, 32'h0000_001F);
        for (int a = 7; a < 10; a++) rd_check("R9 stage mask", 4'(a), 32'h0000_7FFF);
        rd_check("R9 unmapped", 4'd12, 32'd0);

        // Working configuration
        wr("R9 cfg", 4'd2, 32'h1060);
        wr("R9 cfg", 4'd3, 32'h1040);
        wr("R9 cfg", 4'd4, 32'h1000);
        wr("R9 cfg", 4'd5, 32'h10A0);
        wr("R9 cfg", 4'd6, 32'h0);
        wr("R9 cfg", 4'd7, 32'h1000);
        wr("R9 cfg", 4'd8, 32'h1030);
        wr("R9 cfg", 4'd9, 32'h1060);

        // R3: first sample silent, invalid sample ignored
        one("R3 first sample", 0, 16'h1100, 1'b1);
        check("R3 first sample no event", reg_rdata, 32'd0);
        one("R3 invalid flag", 0, 16'h0F00, 1'b0);
        check("R3 invalid no event", reg_rdata, 32'd0);
        // R4: hot and high offset crossing on channel 0 (bits 1,3,4)
        one("R4 hot crossing", 0, 16'h0F00, 1'b1);
        check("R2 R4 channel 0 bits", reg_rdata, 32'h0000_001A);
        idle("R8 irq follows");
        check("R8 irq high", {31'd0, irq}, 32'd1);
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);

        // R5: cold and low offset crossing on channel 1 (bits 5,7)
        one("R5 prime", 1, 16'h1050, 1'b1);
        one("R5 cold crossing", 1, 16'h10B0, 1'b1);
        check("R2 R5 channel 1 bits", reg_rdata, 32'h0000_00A0);
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);

        // R2: channel 3 group and timeout bit
        one("R2 prime", 3, 16'h1100, 1'b1);
        one("R2 channel 3", 3, 16'h0F00, 1'b1);
        check("R2 channel 3 bits", reg_rdata & 32'h07C0_0000, 32'h0680_0000);
        cycle("R2 timeout", 4'd0, 4'd0, 64'd0, 1'b1, 1'b0, 4'd0, 32'd0);
        check("R2 timeout bit", reg_rdata & 32'h0000_8000, 32'h0000_8000);
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);

        // R6: once mode on channel 2 (normal-to-hot is bit 14)
        wr("R6 once mode", 4'd6, 32'h10);
        one("R6 prime", 2, 16'h1100, 1'b1);
        one("R6 first hot", 2, 16'h0F00, 1'b1);
        check("R6 first ntoh", reg_rdata & 32'h0000_4800, 32'h0000_4800);
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);
        one("R6 warm not cold", 2, 16'h1080, 1'b1);
        one("R6 second hot", 2, 16'h0F00, 1'b1);
        check("R6 disarmed no ntoh", reg_rdata & 32'h0000_4800, 32'h0000_0800);
        one("R6 back to cold", 2, 16'h1100, 1'b1);
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);
        one("R6 rearmed hot", 2, 16'h0F00, 1'b1);
        check("R6 rearmed ntoh", reg_rdata & 32'h0000_4800, 32'h0000_4800);

        // R7: set and clear in the same cycle on channel 0
        one("R7 prime", 0, 16'h1100, 1'b1);
        cycle("R7 set with clear", 4'b0001, 4'b0001, 64'h0F00, 1'b0, 1'b1, 4'd0, 32'hFFFF_FFFF);
        check("R7 set wins", reg_rdata & 32'h0000_000A, 32'h0000_000A);

        // R8: masked status keeps irq low
        wr("R8 mask off", 4'd1, 32'd0);
        idle("R8 masked");
        check("R8 irq low when masked", {31'd0, irq}, 32'd0);
        wr("R8 mask on", 4'd1, 32'hFFFF_FFFF);

        // R10 R11: hottest mode
        wr("R10 hottest mode", 4'd6, 32'h1);
        cycle("R10 prime all", 4'hF, 4'hF, {4{16'h1100}}, 1'b0, 1'b0, 4'd0, 32'd0);
        idle("R11 settle");
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);
        one("R10 one channel hot", 2, 16'h0FF0, 1'b1);
        idle("R11 stage edge");
        check("R10 R11 hottest all stages", reg_rdata & 32'hE000_0000, 32'hE000_0000);

        // R10 R11: single selected channel 0
        wr("R10 select channel 0", 4'd6, 32'h2);
        idle("R11 settle");
        wr("R7 clear all", 4'd0, 32'hFFFF_FFFF);
        one("R10 channel 0 warm", 0, 16'h1040, 1'b1);
        idle("R11 stage edge");
        check("R10 R11 selected stage 3 only", reg_rdata & 32'hE000_0000, 32'h8000_0000);

        // Random traffic: R2 R4 R5 R6 R7 R8 R10 R11
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  stb, vld;
            logic [63:0] codes;
            int          r;
            bit          tmo;
            for (int s = 0; s < 4; s++) begin
                stb[s] = $urandom_range(0, 1) == 1;
                vld[s] = $urandom_range(0, 7) != 0;
                codes[s*16 +: 16] = 16'($urandom_range(16'h1100, 16'h0F80));
            end
            tmo = $urandom_range(0, 15) == 0;
            r = $urandom_range(0, 15);
            if (r < 2)
                cycle("R7 random clear", stb, vld, codes, tmo, 1'b1, 4'd0, $urandom);
            else if (r == 2)
                cycle("R6 R10 random ctrl", stb, vld, codes, tmo, 1'b1, 4'd6, 32'($urandom_range(0, 31)));
            else if (r == 3)
                cycle("R8 random enable", stb, vld, codes, tmo, 1'b1, 4'd1, $urandom);
            else
                cycle("R2 R4 R5 R11 random", stb, vld, codes, tmo, 1'b0, 4'd0, 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule